// File: doc/BRIEF.md
# Keyed-Sequence Software Watchdog Timer

This block guards against software that hangs in a loop with no way out. A down-counter runs from a programmable limit. When it passes zero the block emits a one-cycle request. A configuration bit routes that request either to a soft-reset request line or to a non-maskable interrupt line. The counter then reloads and keeps running, and a sticky flag records the timeout.

Software keeps the timer from expiring by writing two fixed keys to a service register, first 0x556C and then 0xAA39. Only the second key reloads the counter. Any other bus traffic may fall between the two writes. A wrong value sends the sequence back to its start.

The enable and route bits accept one control write after reset and are frozen after that. The limit and the prescale option stay writable at all times. A simple single-cycle write bus with a combinational read path gives access to three registers:
- control at address 0
- service at address 1
- status at address 2

Top module: `kwdt_top`

## Requirements
- R1: After reset the control register (address 0) reads 0xFFFF0005. Its fields are: bit0 enable = 1, bit1 route = 0 (0 selects reset, 1 selects interrupt), bit2 prescale = 1, bit3 lock = 0 (read-only), bits [31:16] limit = 0xFFFF. The timeout flag, status bit16, reads 0.
- R2: Writing 0x556C and then 0xAA39 to the service register (address 1, bits [15:0]) reloads the counter. In the cycle after the second write, status bits [15:0] read the limit.
- R3: Neither key reloads the counter on its own. Any value other than 0xAA39 written after 0x556C, including 0x556C again, returns the sequencer to its start without a reload. A following 0xAA39 then does not reload.
- R4: Writes to other addresses and reads of any address between the two keys leave the sequence armed.
- R5: With prescale off and limit N, the expiry pulse appears N+1 clock cycles after the edge that takes the reload. It lasts exactly one cycle.
- R6: With route 0 the pulse appears on `rst_req` only. With route 1 it appears on `nmi_req` only. The two outputs are never high together.
- R7: At expiry the counter reloads to the limit and status bit16 sets. Writing 1 to status bit16 (address 2) clears it.
- R8: The first control write after reset sets enable and route and sets the lock bit. Later control writes leave enable and route unchanged but still update the limit and prescale.
- R9: With enable 0 the counter holds its value and no expiry pulse occurs.
- R10: With prescale on, the counter steps once every 2^PRE_W cycles. A reload restarts the prescaler. Expiry therefore follows (N+1)*2^PRE_W cycles after the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| rst_req | output | 1 | One-cycle soft-reset request on expiry |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request on expiry |

## Verification
The bench builds the block with PRE_W = 4 and keeps CNT_W = 16. A prescaled expiry of a small limit then lands within a hundred cycles, and the tick cadence and the prescaler restart on reload can both be checked exactly. With prescale off, limits of 5 to 11 expose the exact expiry cycle on each route. A limit of 60000 keeps expiry out of the way during the key-sequence tests, so any status read equal to the limit can only come from a reload by the key sequence.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int ADDR_W = 2;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_SVC  = 2'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

   // control field positions
   localparam int B_EN   = 0;
   localparam int B_SEL  = 1;
   localparam int B_PRE  = 2;
   localparam int B_LOCK = 3;
   localparam int B_LIM  = 16;
   // status field positions
   localparam int B_FLAG = 16;

   typedef enum logic {K_IDLE, K_ARMED} key_st_e;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq #(
   parameter int KEY_W = 16,
   parameter logic [KEY_W-1:0] KEY_A = 16'h556C,
   parameter logic [KEY_W-1:0] KEY_B = 16'hAA39
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             svc_wr,
   input  logic [KEY_W-1:0] key,
   output logic             reload,
   output logic             armed
);
   import kwdt_pkg::*;

   key_st_e st_q, st_d;

   always_comb begin
      st_d   = st_q;
      reload = 1'b0;
      if (svc_wr) begin
         unique case (st_q)
            K_IDLE:  st_d = (key == KEY_A) ? K_ARMED : K_IDLE;
            K_ARMED: begin
               st_d   = K_IDLE;
               reload = (key == KEY_B);
            end
            default: st_d = K_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= K_IDLE;
      else        st_q <= st_d;
   end

   assign armed = (st_q == K_ARMED);
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pre_en,
   input  logic restart,
   output logic tick
);
   generate
      if (PRE_W == 0) begin : g_none
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ pre_en ^ restart;
         assign tick = run;
      end else begin : g_div
         logic [PRE_W-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    ph_q <= '0;
            else if (restart || !pre_en)   ph_q <= '0;
            else if (run)                  ph_q <= ph_q + 1'b1;
         end
         assign tick = run && (!pre_en || (&ph_q));
      end
   endgenerate
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             svc_reload,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             fire
);
   logic [CNT_W-1:0] cnt_q;

   // expiry wins over a same-cycle service reload; both reload the limit
   assign fire = tick && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '1;
      else if (fire || svc_reload) cnt_q <= limit;
      else if (tick)               cnt_q <= cnt_q - 1'b1;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
   parameter int CNT_W = 16,
   parameter int PRE_W = 16,
   parameter logic [15:0] KEY_A = 16'h556C,
   parameter logic [15:0] KEY_B = 16'hAA39
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        rst_req,
   output logic        nmi_req
);
   import kwdt_pkg::*;

   localparam int LIM_PAD = 16 - CNT_W;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("kwdt_top: CNT_W must be 1..16");
      end
      if (PRE_W < 0 || PRE_W > 24) begin : g_bad_pre
         $error("kwdt_top: PRE_W must be 0..24");
      end
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("kwdt_top: the two keys must differ");
      end
   endgenerate

   logic             en_q, sel_q, pre_q, lock_q, flag_q;
   logic [CNT_W-1:0] lim_q;
   logic             wr_ctrl, wr_svc, wr_stat;
   logic             svc_reload, armed, tick, fire;
   logic [CNT_W-1:0] cnt;
   logic             rst_q, nmi_q;

   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_svc  = wr_en && (addr == A_SVC);
   assign wr_stat = wr_en && (addr == A_STAT);

   // control register; enable and route are write-once behind lock_q
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b1;
         sel_q  <= 1'b0;
         pre_q  <= 1'b1;
         lock_q <= 1'b0;
         lim_q  <= '1;
      end else if (wr_ctrl) begin
         pre_q <= wdata[B_PRE];
         lim_q <= wdata[B_LIM +: CNT_W];
         if (!lock_q) begin
            en_q   <= wdata[B_EN];
            sel_q  <= wdata[B_SEL];
            lock_q <= 1'b1;
         end
      end
   end

   // sticky timeout flag, write-one-to-clear, set has priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q <= 1'b0;
      else if (fire)                       flag_q <= 1'b1;
      else if (wr_stat && wdata[B_FLAG])   flag_q <= 1'b0;
   end

   kwdt_keyseq #(.KEY_W(16), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_keys (
      .clk    (clk),
      .rst_n  (rst_n),
      .svc_wr (wr_svc),
      .key    (wdata[15:0]),
      .reload (svc_reload),
      .armed  (armed)
   );

   kwdt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .pre_en  (pre_q),
      .restart (svc_reload),
      .tick    (tick)
   );

   kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .svc_reload (svc_reload),
      .limit      (lim_q),
      .cnt        (cnt),
      .fire       (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q <= 1'b0;
         nmi_q <= 1'b0;
      end else begin
         rst_q <= fire && !sel_q;
         nmi_q <= fire &&  sel_q;
      end
   end

   assign rst_req = rst_q;
   assign nmi_req = nmi_q;

   logic [15:0] lim_ext, cnt_ext;
   generate
      if (LIM_PAD > 0) begin : g_pad
         assign lim_ext = {{LIM_PAD{1'b0}}, lim_q};
         assign cnt_ext = {{LIM_PAD{1'b0}}, cnt};
      end else begin : g_full
         assign lim_ext = lim_q;
         assign cnt_ext = cnt;
      end
   endgenerate

   always_comb begin
      unique case (addr)
         A_CTRL:  rdata = {lim_ext, 12'd0, lock_q, pre_q, sel_q, en_q};
         A_STAT:  rdata = {15'd0, flag_q, cnt_ext};
         default: rdata = '0;
      endcase
   end

   logic unused_armed;
   assign unused_armed = armed;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
   parameter int CNT_W = 16,
   parameter logic [15:0] KEY_A = 16'h556C
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [31:0]      wdata,
   input logic             rst_req,
   input logic             nmi_req,
   input logic             en_q,
   input logic             sel_q,
   input logic             lock_q,
   input logic [CNT_W-1:0] lim_q,
   input logic [CNT_W-1:0] cnt,
   input logic             svc_reload,
   input logic             fire,
   input logic             armed
);
   assert_never_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && nmi_req));

   assert_route_nmi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> $past(sel_q));

   assert_route_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !$past(sel_q));

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((rst_req || nmi_req) && cnt != '0) |=> !(rst_req || nmi_req));

   assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(en_q) && $stable(sel_q) && lock_q));

   assert_reload_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_reload || fire) |=> (cnt == $past(lim_q)));

   assert_arm_by_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(wr_en && addr == 2'd1 && wdata[15:0] == KEY_A));

   assert_halt_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !svc_reload) |=> ($stable(cnt) && !rst_req && !nmi_req));
endmodule

bind kwdt_top kwdt_checker #(.CNT_W(CNT_W), .KEY_A(KEY_A)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr       (addr),
   .wdata      (wdata),
   .rst_req    (rst_req),
   .nmi_req    (nmi_req),
   .en_q       (en_q),
   .sel_q      (sel_q),
   .lock_q     (lock_q),
   .lim_q      (lim_q),
   .cnt        (cnt),
   .svc_reload (svc_reload),
   .fire       (fire),
   .armed      (armed)
);

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;
   localparam int PRE_W = 4;
   localparam logic [15:0] KA = 16'h556C;
   localparam logic [15:0] KB = 16'hAA39;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_req, nmi_req;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   kwdt_top #(.CNT_W(16), .PRE_W(PRE_W)) u_kwdt_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rst_req(rst_req), .nmi_req(nmi_req)
   );

   function automatic logic [31:0] ctrl_word(logic en, logic sel, logic pre, logic [15:0] lim);
      return {lim, 13'd0, pre, sel, en};
   endfunction

   function automatic logic [31:0] ctrl_read(logic en, logic sel, logic pre, logic lock, logic [15:0] lim);
      return {lim, 12'd0, lock, pre, sel, en};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // write, then sample status in the cycle right after the write edge
   task automatic wr_op(logic [1:0] a, logic [31:0] d, output logic [31:0] st);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd2;
      #1 st = rdata;
   endtask

   task automatic rd_op(logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   // count cycles from the current negedge until a pulse is seen
   task automatic wait_pulse(string req, int exp_k, logic want_nmi);
      int k = 0;
      logic got_r = 0, got_n = 0;
      for (int i = 1; i <= 5000; i++) begin
         @(negedge clk);
         k = i;
         if (rst_req || nmi_req) begin
            got_r = rst_req; got_n = nmi_req;
            break;
         end
      end
      check(req, k, exp_k);
      check({req, " route"}, {30'd0, got_n, got_r}, want_nmi ? 32'd2 : 32'd1);
      @(negedge clk);
      check({req, " one-cycle"}, {30'd0, nmi_req, rst_req}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      logic [31:0] v, st, v2;
      logic m_armed;
      logic [15:0] lim;
      void'($urandom(32'd20240611));

      do_reset();
      // R1 reset values
      rd_op(2'd0, v);
      check("R1 ctrl reset", v, 32'hFFFF0005);
      rd_op(2'd2, v);
      check("R1 flag reset", {31'd0, v[16]}, 32'd0);

      // R8 first write takes, then lock
      wr_op(2'd0, ctrl_word(1, 0, 0, 16'd10), st);
      rd_op(2'd0, v);
      check("R8 first write", v, ctrl_read(1, 0, 0, 1, 16'd10));
      wr_op(2'd0, ctrl_word(0, 1, 0, 16'd11), st);
      rd_op(2'd0, v);
      check("R8 locked en/sel, limit updates", v, ctrl_read(1, 0, 0, 1, 16'd11));
      wr_op(2'd0, ctrl_word(0, 1, 0, 16'd60000), st);

      // R2 / R3 basic sequence
      wr_op(2'd1, {16'd0, KA}, st);
      check("R3 first key no reload", {31'd0, st[15:0] == 16'd60000}, 32'd0);
      wr_op(2'd1, {16'd0, KB}, st);
      check("R2 reload", {16'd0, st[15:0]}, 32'd60000);

      // R3 wrong second key, including repeated first key
      wr_op(2'd1, {16'd0, KA}, st);
      wr_op(2'd1, {16'd0, KA}, st);
      wr_op(2'd1, {16'd0, KB}, st);
      check("R3 repeated first key breaks", {31'd0, st[15:0] == 16'd60000}, 32'd0);
      wr_op(2'd1, {16'd0, KA}, st);
      wr_op(2'd1, 32'h0000_1234, st);
      wr_op(2'd1, {16'd0, KB}, st);
      check("R3 wrong value breaks", {31'd0, st[15:0] == 16'd60000}, 32'd0);
      wr_op(2'd1, {16'd0, KB}, st);
      check("R3 second key alone", {31'd0, st[15:0] == 16'd60000}, 32'd0);

      // R4 unrelated traffic between keys
      wr_op(2'd1, {16'd0, KA}, st);
      wr_op(2'd3, 32'hDEAD_BEEF, st);
      rd_op(2'd0, v);
      rd_op(2'd1, v);
      wr_op(2'd0, ctrl_word(1, 0, 0, 16'd60000), st);
      wr_op(2'd2, 32'd0, st);
      repeat (20) @(negedge clk);
      wr_op(2'd1, {16'd0, KB}, st);
      check("R4 traffic between keys", {16'd0, st[15:0]}, 32'd60000);

      // constrained random key traffic against a sequencer model (R2, R3, R4)
      m_armed = 1'b0;
      for (int i = 0; i < 300; i++) begin
         int op;
         logic [15:0] d;
         logic exp_rl;
         op = int'($urandom % 5);
         if (op == 3) begin
            wr_op(2'd3, $urandom, st);
         end else if (op == 4) begin
            rd_op(2'($urandom % 4), v);
         end else begin
            d = (op == 0) ? KA : (op == 1) ? KB : 16'($urandom);
            exp_rl  = m_armed && (d == KB);
            m_armed = !m_armed && (d == KA);
            wr_op(2'd1, {16'd0, d}, st);
            check(exp_rl ? "R2 random reload" : "R3 random no reload",
                  {31'd0, st[15:0] == 16'd60000}, {31'd0, exp_rl});
         end
      end
      // leave the sequencer idle
      wr_op(2'd1, 32'd0, st);

      // R5 / R6 / R7 expiry on reset route
      wr_op(2'd0, ctrl_word(1, 0, 0, 16'd10), st);
      wr_op(2'd2, 32'h0001_0000, st);
      wr_op(2'd1, {16'd0, KA}, st);
      wr_op(2'd1, {16'd0, KB}, st);
      check("R2 reload small limit", {16'd0, st[15:0]}, 32'd10);
      wait_pulse("R5 expiry cycle", 11, 1'b0);
      // one cycle after the pulse: counter stepped once from the limit
      #1 v = rdata;
      check("R7 reload at expiry", {16'd0, v[15:0]}, 32'd9);
      check("R7 flag set", {31'd0, v[16]}, 32'd1);
      wr_op(2'd2, 32'h0001_0000, st);
      check("R7 flag cleared", {31'd0, st[16]}, 32'd0);
      // R7 keeps counting: next pulse 11 cycles after the previous one
      wr_op(2'd1, {16'd0, KA}, st);
      wr_op(2'd1, {16'd0, KB}, st);
      wait_pulse("R7 re-arms", 11, 1'b0);
      wait_pulse("R7 periodic", 10, 1'b0);

      // R10 prescaled expiry: limit 3, steps every 16 cycles
      wr_op(2'd0, ctrl_word(1, 0, 1, 16'd3), st);
      wr_op(2'd1, {16'd0, KA}, st);
      wr_op(2'd1, {16'd0, KB}, st);
      check("R10 reload", {16'd0, st[15:0]}, 32'd3);
      wait_pulse("R10 prescaled expiry", (3 + 1) * (1 << PRE_W), 1'b0);

      // R6 interrupt route
      do_reset();
      wr_op(2'd0, ctrl_word(1, 1, 0, 16'd5), st);
      wr_op(2'd1, {16'd0, KA}, st);
      wr_op(2'd1, {16'd0, KB}, st);
      wait_pulse("R6 nmi route", 6, 1'b1);

      // R9 disabled: counter frozen, no pulse
      do_reset();
      wr_op(2'd0, ctrl_word(0, 0, 0, 16'd2), st);
      rd_op(2'd0, v);
      check("R9 enable cleared", {31'd0, v[0]}, 32'd0);
      rd_op(2'd2, v);
      begin
         logic seen = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rst_req || nmi_req) seen = 1;
         end
         check("R9 no pulse when disabled", {31'd0, seen}, 32'd0);
      end
      rd_op(2'd2, v2);
      check("R9 counter frozen", {16'd0, v2[15:0]}, {16'd0, v[15:0]});

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule